// File: doc/BRIEF.md
# Elastic-Buffer Jitter Attenuator

This block smooths the timing of a serial bit stream. Bits arrive as single-cycle strobes that are synchronous to a fast master clock but spaced irregularly. Each arriving bit is written into a bit-wide elastic buffer. A numerically controlled oscillator, also running on the master clock, produces an evenly paced read strobe that takes the bits back out. The oscillator's increment is steered by a first-order loop that acts on the buffer's fill error relative to half depth. A single select bit sets the loop gain, which trades lock speed for smoothing.

The buffer depth can be set at run time to 32, 64 or 128 bits. After reset, and after any change of depth, the buffer is re-centred. It then holds half its depth in zero bits, which gives a fixed latency of half the depth. Two sticky flags record overflow and underflow. Each flag stays set until its own write-one-to-clear strobe bit is pulsed.

An optional limit mode overrides the loop near the buffer edges. Close to full it reads at the maximum rate, and close to empty it stops reading. A placement select routes the block into the transmit or receive path, or disables it. When the block is disabled the stream passes straight through.

Top module: `jitter_atten`

## Requirements
- R1: `depthSel` 00 selects 32 bits, 01 selects 64 bits, and 10 or 11 selects 128 bits. After reset, and two cycles after any change of `depthSel`, `fillLevel` equals half the depth and both status flags read 0.
- R2: With the buffer neither overflowing nor underflowing, the bits on `outBit` (taken when `outStrobe` is 1) are the input bits in their original order, preceded by exactly half-depth zero bits.
- R3: A write arriving when the buffer is full, with no read in the same cycle, is dropped and sets `ovfFlag`. `ovfFlag` stays 1 until it is cleared.
- R4: A read strobe that occurs while the buffer is empty outputs a 0 bit and sets `udfFlag`. `udfFlag` stays 1 until it is cleared.
- R5: `statusClr` bit 0 clears `ovfFlag` and bit 1 clears `udfFlag`. Each clear bit leaves the other flag unchanged, and a set event in the same cycle wins over a clear.
- R6: With `limitEn`=1 and the fill level at or below 4, read strobes stop. With no writes, the fill level settles at 4 and no underflow occurs.
- R7: With `limitEn`=1 and the fill level at or above depth-4, reads run at the maximum rate. A write on every cycle then keeps the fill level at no more than depth-3 and causes no overflow.
- R8: With zero fill error, the read rate is NOM_INC/2^ACC_W strobes per cycle (1 in 8 by default). `bwSel`=1 multiplies the error by 64, and `bwSel`=0 multiplies it by 8. The wide setting therefore pulls the read rate further down when the fill level is below half.
- R9: `placeSel` 01 asserts `txActive` and 10 asserts `rxActive`. `placeSel` 00 or 11 disables the block: `outStrobe` and `outBit` follow `inStrobe` and `inBit` in the same cycle, and the buffer is held re-centred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inStrobe | input | 1 | Jittered input bit strobe |
| inBit | input | 1 | Input data bit, valid with inStrobe |
| depthSel | input | 2 | Buffer depth select |
| bwSel | input | 1 | Loop gain select (1 = wide) |
| limitEn | input | 1 | Limit mode enable |
| placeSel | input | 2 | Path placement / disable select |
| statusClr | input | 2 | Write-one-to-clear strobes for the status flags |
| outStrobe | output | 1 | Smoothed read strobe |
| outBit | output | 1 | Output data bit, valid with outStrobe |
| ovfFlag | output | 1 | Sticky overflow flag |
| udfFlag | output | 1 | Sticky underflow flag |
| fillLevel | output | 8 | Current buffer fill in bits |
| txActive | output | 1 | Block placed in transmit path |
| rxActive | output | 1 | Block placed in receive path |

## Verification
A corrupted read or write pointer shows up at the first read strobe after the fault: `outBit` departs from the input sequence delayed by half depth, which is roughly eight cycles at the nominal rate. A wrong fill count shows up at once on `fillLevel`. It is also visible within a few hundred cycles as a wrong settling point under limit mode, or as a wrong read-strobe count when the loop gain is compared. Errors in the flag logic are seen on the cycle after the set or clear event.

// File: rtl/ja_pkg.sv
package ja_pkg;
  typedef struct packed {
    logic wrEn;      // accepted write
    logic rdEn;      // read with data present
    logic rdTick;    // any read strobe from the oscillator
    logic recentre;  // clear and re-centre the buffer
  } jaCtl_t;
endpackage

// File: rtl/ja_datapath.sv
module ja_datapath
  import ja_pkg::*;
#(
  parameter int MAX_DEPTH = 128,
  localparam int AW = $clog2(MAX_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  jaCtl_t        ctl,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic          inBit,
  output logic          rdBit
);
  logic [MAX_DEPTH-1:0] mem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem   <= '0;
      rdBit <= 1'b0;
    end else if (ctl.recentre) begin
      mem   <= '0;
      rdBit <= 1'b0;
    end else begin
      if (ctl.wrEn) mem[wrAddr] <= inBit;
      if (ctl.rdEn) rdBit <= mem[rdAddr];
      else if (ctl.rdTick) rdBit <= 1'b0;
    end
  end

  // R4: an empty read delivers a zero bit
  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdTick && !ctl.rdEn && !ctl.recentre) |=> !rdBit);
endmodule

// File: rtl/ja_ctrl.sv
module ja_ctrl
  import ja_pkg::*;
#(
  parameter int MAX_DEPTH    = 128,
  parameter int ACC_W        = 16,
  parameter int NOM_INC      = 8192,
  parameter int LIMIT_MARGIN = 4,
  parameter int GAIN_NARROW  = 3,
  parameter int GAIN_WIDE    = 6,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int FW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inStrobe,
  input  logic [1:0]    depthSel,
  input  logic          bwSel,
  input  logic          limitEn,
  input  logic          bypass,
  input  logic [1:0]    statusClr,
  output jaCtl_t        ctl,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [FW-1:0] fillLevel,
  output logic          ovfFlag,
  output logic          udfFlag,
  output logic          outStrobe
);
  localparam int SW      = ACC_W + 2;
  localparam int INC_MAX = (1 << ACC_W) - 1;

  logic [1:0]    depthQ;
  logic [1:0]    dShift;
  logic [FW-1:0] depth, half, fill;
  logic [AW-1:0] mask, wrPtr, rdPtr;
  logic [ACC_W-1:0] acc, inc;
  logic [ACC_W:0]   sum;
  logic signed [SW-1:0] errS, corrS, incRawS;
  logic recentre, nearFull, nearEmpty, tick, rdOk, wrOk, ovfSet, udfSet;

  always_comb begin
    dShift   = depthSel[1] ? 2'd0 : (depthSel[0] ? 2'd1 : 2'd2);
    depth    = FW'(MAX_DEPTH) >> dShift;
    half     = depth >> 1;
    mask     = AW'(depth - 1'b1);
    recentre = bypass || (depthSel != depthQ);
    errS     = $signed(SW'(fill)) - $signed(SW'(half));
    corrS    = bwSel ? (errS <<< GAIN_WIDE) : (errS <<< GAIN_NARROW);
    incRawS  = $signed(SW'(NOM_INC)) + corrS;
    nearFull  = fill >= (depth - FW'(LIMIT_MARGIN));
    nearEmpty = fill <= FW'(LIMIT_MARGIN);
    if (limitEn && nearEmpty)               inc = '0;
    else if (limitEn && nearFull)           inc = ACC_W'(INC_MAX);
    else if (incRawS < 0)                   inc = '0;
    else if (incRawS > $signed(SW'(INC_MAX))) inc = ACC_W'(INC_MAX);
    else                                    inc = incRawS[ACC_W-1:0];
    sum    = {1'b0, acc} + {1'b0, inc};
    tick   = sum[ACC_W] && !recentre;
    rdOk   = tick && (fill != '0);
    udfSet = tick && (fill == '0);
    wrOk   = inStrobe && !recentre && ((fill != depth) || rdOk);
    ovfSet = inStrobe && !recentre && (fill == depth) && !rdOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= depthSel;
      acc <= '0; fill <= half; wrPtr <= AW'(half); rdPtr <= '0;
      ovfFlag <= 1'b0; udfFlag <= 1'b0; outStrobe <= 1'b0;
    end else if (recentre) begin
      depthQ <= depthSel;
      acc <= '0; fill <= half; wrPtr <= AW'(half); rdPtr <= '0;
      ovfFlag <= 1'b0; udfFlag <= 1'b0; outStrobe <= 1'b0;
    end else begin
      acc       <= sum[ACC_W-1:0];
      outStrobe <= tick;
      if (wrOk) wrPtr <= AW'(wrPtr + 1'b1) & mask;
      if (rdOk) rdPtr <= AW'(rdPtr + 1'b1) & mask;
      case ({wrOk, rdOk})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      ovfFlag <= ovfSet || (ovfFlag && !statusClr[0]);
      udfFlag <= udfSet || (udfFlag && !statusClr[1]);
    end
  end

  always_comb begin
    ctl.wrEn     = wrOk;
    ctl.rdEn     = rdOk;
    ctl.rdTick   = tick;
    ctl.recentre = recentre;
    wrAddr       = wrPtr;
    rdAddr       = rdPtr;
    fillLevel    = fill;
  end

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    !recentre |-> fill <= depth);
  assert_recentre_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    recentre |=> (!ovfFlag && !udfFlag));
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !statusClr[0] && !recentre) |=> ovfFlag);
  assert_udf_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (udfFlag && !statusClr[1] && !recentre) |=> udfFlag);
  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr[0] && !ovfSet) |=> !ovfFlag);
  assert_limit_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (limitEn && !recentre && nearEmpty && !inStrobe) |=> fill == $past(fill));
endmodule

// File: rtl/jitter_atten.sv
module jitter_atten
  import ja_pkg::*;
#(
  parameter int MAX_DEPTH    = 128,
  parameter int ACC_W        = 16,
  parameter int NOM_INC      = 8192,
  parameter int LIMIT_MARGIN = 4,
  parameter int GAIN_NARROW  = 3,
  parameter int GAIN_WIDE    = 6,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int FW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inStrobe,
  input  logic          inBit,
  input  logic [1:0]    depthSel,
  input  logic          bwSel,
  input  logic          limitEn,
  input  logic [1:0]    placeSel,
  input  logic [1:0]    statusClr,
  output logic          outStrobe,
  output logic          outBit,
  output logic          ovfFlag,
  output logic          udfFlag,
  output logic [FW-1:0] fillLevel,
  output logic          txActive,
  output logic          rxActive
);
  jaCtl_t        ctl;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          bypass, bufStrobe, bufBit;

  assign txActive = (placeSel == 2'b01);
  assign rxActive = (placeSel == 2'b10);
  assign bypass   = !(txActive || rxActive);

  ja_ctrl #(
    .MAX_DEPTH(MAX_DEPTH), .ACC_W(ACC_W), .NOM_INC(NOM_INC),
    .LIMIT_MARGIN(LIMIT_MARGIN), .GAIN_NARROW(GAIN_NARROW), .GAIN_WIDE(GAIN_WIDE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .depthSel(depthSel),
    .bwSel(bwSel), .limitEn(limitEn), .bypass(bypass), .statusClr(statusClr),
    .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr), .fillLevel(fillLevel),
    .ovfFlag(ovfFlag), .udfFlag(udfFlag), .outStrobe(bufStrobe)
  );

  ja_datapath #(.MAX_DEPTH(MAX_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inBit(inBit), .rdBit(bufBit)
  );

  assign outStrobe = bypass ? inStrobe : bufStrobe;
  assign outBit    = bypass ? inBit    : bufBit;
endmodule

// File: tb/jitter_atten_tb_top.sv
`timescale 1ns/1ps
module jitter_atten_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inStrobe = 1'b0, inBit = 1'b0, bwSel = 1'b1, limitEn = 1'b0;
  logic [1:0] depthSel = 2'b00, placeSel = 2'b01, statusClr = 2'b00;
  logic outStrobe, outBit, ovfFlag, udfFlag, txActive, rxActive;
  logic [7:0] fillLevel;

  int vectors = 0, errors = 0;
  int tickCnt = 0;
  logic lastBit = 1'b1;
  logic collecting = 1'b0;
  logic gotQ[$];
  logic expQ[$];

  always #5 clk = ~clk;

  jitter_atten dut_i (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .inBit(inBit),
    .depthSel(depthSel), .bwSel(bwSel), .limitEn(limitEn), .placeSel(placeSel),
    .statusClr(statusClr), .outStrobe(outStrobe), .outBit(outBit),
    .ovfFlag(ovfFlag), .udfFlag(udfFlag), .fillLevel(fillLevel),
    .txActive(txActive), .rxActive(rxActive)
  );

  always @(negedge clk) begin
    if (rstN && outStrobe && placeSel inside {2'b01, 2'b10}) begin
      tickCnt = tickCnt + 1;
      lastBit = outBit;
      if (collecting) gotQ.push_back(outBit);
    end
  end

  function automatic int halfOf(input logic [1:0] sel);
    return sel[1] ? 64 : (sel[0] ? 32 : 16);
  endfunction

  task automatic chk(input string req, input logic ok, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeBit(input logic b);
    inStrobe = 1'b1; inBit = b;
    @(negedge clk);
    inStrobe = 1'b0;
  endtask

  task automatic setDepth(input logic [1:0] d);
    depthSel = d;
    idle(2);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n;
    int nNarrow, nWide;
    void'($urandom(32'd5150));
    idle(3);
    // R1/R9 reset state
    chk("R1 reset fill", fillLevel == 8'd16, fillLevel, 16);
    chk("R1 reset flags", {ovfFlag, udfFlag} == 2'b00, {ovfFlag, udfFlag}, 0);
    chk("R9 tx placement", {txActive, rxActive} == 2'b10, {txActive, rxActive}, 2);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle strobe", outStrobe == 1'b0, outStrobe, 0);

    // R2 random jittered stream, delay of half depth
    for (int i = 0; i < 16; i++) expQ.push_back(1'b0);
    collecting = 1'b1;
    for (int p = 0; p < 200; p++) begin
      int d;
      logic b;
      d = $urandom_range(3, 0);
      b = 1'($urandom);
      expQ.push_back(b); writeBit(b); idle(7 + d);
      b = 1'($urandom);
      expQ.push_back(b); writeBit(b); idle(7 - d);
    end
    collecting = 1'b0;
    n = gotQ.size();
    chk("R2 output count", n > 380 && n <= expQ.size(), n, 400);
    for (int i = 0; i < n && i < expQ.size(); i++)
      chk($sformatf("R2 bit %0d", i), gotQ[i] == expQ[i], gotQ[i], expQ[i]);
    chk("R2 no ovf", ovfFlag == 1'b0, ovfFlag, 0);
    chk("R2 no udf", udfFlag == 1'b0, udfFlag, 0);

    // R4 underflow by starving the buffer
    idle(400);
    chk("R4 udf set", udfFlag == 1'b1, udfFlag, 1);
    chk("R4 fill empty", fillLevel == 8'd0, fillLevel, 0);
    chk("R4 empty bit zero", lastBit == 1'b0, lastBit, 0);

    // R1 depth change re-centres
    setDepth(2'b01);
    chk("R1 recentre fill 64", fillLevel == 8'd32, fillLevel, 32);
    chk("R1 recentre flags", {ovfFlag, udfFlag} == 2'b00, {ovfFlag, udfFlag}, 0);
    setDepth(2'b11);
    chk("R1 depth 11 fill", fillLevel == 8'd64, fillLevel, 64);
    setDepth(2'b00);
    chk("R1 depth 00 fill", fillLevel == 8'd16, fillLevel, 16);

    // R3 overflow and R5 clear
    for (int i = 0; i < 40; i++) writeBit(1'b1);
    chk("R3 ovf set", ovfFlag == 1'b1, ovfFlag, 1);
    chk("R3 fill bound", fillLevel <= 8'd32, fillLevel, 32);
    idle(20);
    chk("R3 ovf sticky", ovfFlag == 1'b1, ovfFlag, 1);
    statusClr = 2'b10; @(negedge clk); statusClr = 2'b00;
    chk("R5 udf clear keeps ovf", ovfFlag == 1'b1, ovfFlag, 1);
    statusClr = 2'b01; @(negedge clk); statusClr = 2'b00;
    chk("R5 ovf cleared", ovfFlag == 1'b0, ovfFlag, 0);

    // R6 limit near empty
    limitEn = 1'b1;
    setDepth(2'b01); setDepth(2'b00);
    idle(400);
    chk("R6 fill settles", fillLevel == 8'd4, fillLevel, 4);
    chk("R6 no udf", udfFlag == 1'b0, udfFlag, 0);

    // R7 limit near full
    setDepth(2'b01); setDepth(2'b00);
    inStrobe = 1'b1; inBit = 1'b1;
    idle(80);
    inStrobe = 1'b0;
    chk("R7 no ovf", ovfFlag == 1'b0, ovfFlag, 0);
    chk("R7 fill capped", fillLevel <= 8'd29 && fillLevel >= 8'd27, fillLevel, 28);
    limitEn = 1'b0;

    // R8 loop gain comparison
    bwSel = 1'b0;
    setDepth(2'b01); depthSel = 2'b10; @(negedge clk);
    tickCnt = 0; idle(400); nNarrow = tickCnt;
    bwSel = 1'b1;
    setDepth(2'b01); depthSel = 2'b10; @(negedge clk);
    tickCnt = 0; idle(400); nWide = tickCnt;
    chk("R8 nominal rate", nNarrow >= 44 && nNarrow <= 51, nNarrow, 50);
    chk("R8 wide pulls harder", nWide < nNarrow, nWide, nNarrow - 1);

    // R9 bypass and placement
    placeSel = 2'b00; inStrobe = 1'b1; inBit = 1'b1; #1;
    chk("R9 bypass strobe", outStrobe == 1'b1, outStrobe, 1);
    chk("R9 bypass bit", outBit == 1'b1, outBit, 1);
    inBit = 1'b0; #1;
    chk("R9 bypass bit low", outBit == 1'b0, outBit, 0);
    @(negedge clk); inStrobe = 1'b0; idle(2);
    chk("R9 held centred", fillLevel == 8'd64, fillLevel, 64);
    chk("R9 none active", {txActive, rxActive} == 2'b00, {txActive, rxActive}, 0);
    placeSel = 2'b10; #1;
    chk("R9 rx placement", {txActive, rxActive} == 2'b01, {txActive, rxActive}, 1);
    placeSel = 2'b11; inStrobe = 1'b1; inBit = 1'b1; #1;
    chk("R9 code 11 bypass", outStrobe && outBit, {outStrobe, outBit}, 3);
    @(negedge clk); inStrobe = 1'b0;

    summary();
    $finish;
  end
endmodule